// File: doc/BRIEF.md
# Stream Flush Discard Gate

This gate sits between the read side of a FIFO and a streaming sink that uses a ready/valid handshake with zero ready latency. A beat moves in any cycle where valid and ready are both high. The gate has two modes. In the passing mode it is transparent: data, valid and the three frame markers (start, end and sync) go straight through, and the sink's ready goes straight back upstream. In the draining mode it tells the FIFO it is ready in every cycle and throws away whatever the FIFO offers. The FIFO therefore empties, and nothing reaches the sink.

A single level input, `flush_req`, controls draining. Entry into draining is combinational, so the gate starts discarding in the same cycle that `flush_req` rises. A packet that is cut in half this way loses its remaining beats, and no end marker is invented for it. The parameter `FRAMED_EXIT` sets how draining ends. With `FRAMED_EXIT=0`, forwarding resumes in the first cycle that `flush_req` is low. With `FRAMED_EXIT=1`, the gate keeps discarding after `flush_req` falls. It stops only when a valid start-of-packet beat is offered. That beat is forwarded, so the sink never sees the tail of a packet.

The controller is a three-state machine:
- PASS is the reset state.
- DRAIN is held while `flush_req` is high.
- HUNT applies in framed mode only. It is the state after `flush_req` falls and before a start beat appears.

The named transitions are:
- PASS→DRAIN when `flush_req` rises.
- DRAIN→PASS when `flush_req` is low, in unframed mode, or in framed mode when a start beat is offered.
- DRAIN→HUNT when `flush_req` is low in framed mode and no start beat is offered.
- HUNT→PASS when a start beat is offered.
- HUNT→DRAIN when `flush_req` rises again.

Top module: `stream_flush_gate`

## Requirements
- R1: After reset the gate is in PASS. With `flush_req` low, the first beat offered is forwarded even when it carries no start marker.
- R2: While passing, `dn_data`, `dn_valid`, `dn_sop`, `dn_eop` and `dn_sync` equal the matching upstream inputs in the same cycle.
- R3: While passing, `up_ready` equals `dn_ready` in the same cycle.
- R4: In any cycle where `flush_req` is 1, `up_ready` is 1 regardless of `dn_ready`.
- R5: In any cycle where `flush_req` is 1, `dn_valid`, `dn_sop`, `dn_eop` and `dn_sync` are all 0.
- R6: When `flush_req` rises in the middle of a packet, the remaining beats of that packet are discarded and no end marker reaches the sink.
- R7: With `FRAMED_EXIT=0`, forwarding resumes in the first cycle where `flush_req` is 0.
- R8: With `FRAMED_EXIT=1`, once `flush_req` has fallen, beats offered without a start marker (`up_sop`=0) are accepted (`up_ready`=1) and not forwarded (`dn_valid`=0) until a valid start beat is offered.
- R9: With `FRAMED_EXIT=1`, the first valid start beat offered while `flush_req` is low is forwarded in that same cycle, and the beats after it pass normally.
- R10: With `FRAMED_EXIT=1`, a start beat offered while `flush_req` is still 1 is discarded and does not end the hunt for a packet start.
- R11: A FIFO feeding the gate is empty after `flush_req` has been held high long enough to cover its content, even when `dn_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_req | input | 1 | Level request to drain the upstream FIFO |
| up_data | input | DATA_W | Upstream beat payload |
| up_valid | input | 1 | Upstream beat present |
| up_sop | input | 1 | Upstream start-of-packet marker |
| up_eop | input | 1 | Upstream end-of-packet marker |
| up_sync | input | 1 | Upstream sync marker |
| up_ready | output | 1 | Ready returned to the FIFO |
| dn_data | output | DATA_W | Downstream beat payload |
| dn_valid | output | 1 | Downstream beat present |
| dn_sop | output | 1 | Downstream start-of-packet marker |
| dn_eop | output | 1 | Downstream end-of-packet marker |
| dn_sync | output | 1 | Downstream sync marker |
| dn_ready | input | 1 | Ready from the sink |

## Verification
Some rules are checked on every cycle. While a flush is requested, upstream ready is forced high and the sink sees nothing. Any forwarded beat is an exact copy of the upstream beat, and its ready follows the sink. In framed mode, the first beat forwarded after a flush carries a start marker. In unframed mode, valid is transparent whenever the request is low.

Other properties depend on a sequence of stimuli and are shown only by the bench scenarios:
- the reset state is PASS;
- a packet cut by a flush loses its tail;
- a start beat seen during a flush does not end the hunt;
- a real FIFO model ends up empty after a flush with the sink stalled.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

    typedef enum logic [1:0] {
        SFG_PASS  = 2'd0,
        SFG_DRAIN = 2'd1,
        SFG_HUNT  = 2'd2
    } sfg_state_e;

    localparam int SFG_MARK_W = 3;

endpackage

// File: rtl/sfg_ctrl.sv
module sfg_ctrl
    import sfg_pkg::*;
#(
    parameter bit FRAMED_EXIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req,
    input  logic head_valid,
    input  logic head_sop,
    output logic discard
);

    sfg_state_e state_q;
    sfg_state_e state_d;
    logic       start_here;

    assign start_here = head_valid && head_sop;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SFG_PASS;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SFG_PASS: begin
                if (flush_req) state_d = SFG_DRAIN;
            end
            SFG_DRAIN: begin
                if (!flush_req) begin
                    if (!FRAMED_EXIT || start_here) state_d = SFG_PASS;
                    else                            state_d = SFG_HUNT;
                end
            end
            SFG_HUNT: begin
                if (flush_req)       state_d = SFG_DRAIN;
                else if (start_here) state_d = SFG_PASS;
            end
            default: state_d = SFG_PASS;
        endcase
    end

    // outputs
    always_comb begin
        discard = 1'b1;
        unique case (state_q)
            SFG_PASS:  discard = flush_req;
            SFG_DRAIN: discard = flush_req || (FRAMED_EXIT && !start_here);
            SFG_HUNT:  discard = flush_req || !start_here;
            default:   discard = 1'b1;
        endcase
    end

endmodule

// File: rtl/sfg_lane.sv
module sfg_lane
    import sfg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  discard,
    input  logic [DATA_W-1:0]     in_data,
    input  logic                  in_valid,
    input  logic [SFG_MARK_W-1:0] in_mark,
    output logic                  in_ready,
    output logic [DATA_W-1:0]     out_data,
    output logic                  out_valid,
    output logic [SFG_MARK_W-1:0] out_mark,
    input  logic                  out_ready
);

    assign in_ready  = discard ? 1'b1 : out_ready;
    assign out_valid = in_valid && !discard;
    assign out_data  = in_data;

    // each frame marker is masked by its own gate
    for (genvar m = 0; m < SFG_MARK_W; m++) begin : g_mark
        assign out_mark[m] = in_mark[m] && !discard;
    end

endmodule

// File: rtl/stream_flush_gate.sv
module stream_flush_gate
    import sfg_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter bit FRAMED_EXIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_req,
    input  logic [DATA_W-1:0] up_data,
    input  logic              up_valid,
    input  logic              up_sop,
    input  logic              up_eop,
    input  logic              up_sync,
    output logic              up_ready,
    output logic [DATA_W-1:0] dn_data,
    output logic              dn_valid,
    output logic              dn_sop,
    output logic              dn_eop,
    output logic              dn_sync,
    input  logic              dn_ready
);

    logic                  discard;
    logic [SFG_MARK_W-1:0] mark_in;
    logic [SFG_MARK_W-1:0] mark_out;

    assign mark_in = {up_sync, up_eop, up_sop};

    sfg_ctrl #(
        .FRAMED_EXIT(FRAMED_EXIT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (flush_req),
        .head_valid(up_valid),
        .head_sop  (up_sop),
        .discard   (discard)
    );

    sfg_lane #(
        .DATA_W(DATA_W)
    ) u_lane (
        .discard  (discard),
        .in_data  (up_data),
        .in_valid (up_valid),
        .in_mark  (mark_in),
        .in_ready (up_ready),
        .out_data (dn_data),
        .out_valid(dn_valid),
        .out_mark (mark_out),
        .out_ready(dn_ready)
    );

    assign dn_sop  = mark_out[0];
    assign dn_eop  = mark_out[1];
    assign dn_sync = mark_out[2];

endmodule

// File: rtl/stream_flush_gate_checker.sv
module stream_flush_gate_checker #(
    parameter int DATA_W      = 32,
    parameter bit FRAMED_EXIT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_req,
    input logic [DATA_W-1:0] up_data,
    input logic              up_valid,
    input logic              up_sop,
    input logic              up_eop,
    input logic              up_sync,
    input logic              up_ready,
    input logic [DATA_W-1:0] dn_data,
    input logic              dn_valid,
    input logic              dn_sop,
    input logic              dn_eop,
    input logic              dn_sync,
    input logic              dn_ready
);

    // set by a flush request, cleared once a start beat has been offered with the request low
    logic hunting_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                  hunting_q <= 1'b0;
        else if (flush_req)          hunting_q <= 1'b1;
        else if (up_valid && up_sop) hunting_q <= 1'b0;
    end

    AST_FLUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> up_ready); // R4

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !(dn_valid || dn_sop || dn_eop || dn_sync)); // R5

    AST_PASS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> (up_ready == dn_ready)); // R3

    AST_PASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> (up_valid && dn_data == up_data && dn_sop == up_sop
                      && dn_eop == up_eop && dn_sync == up_sync)); // R2

    if (FRAMED_EXIT) begin : g_framed
        AST_HUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (hunting_q && up_valid && !up_sop) |-> (up_ready && !dn_valid)); // R8

        AST_FIRST_SOP: assert property (@(posedge clk) disable iff (!rst_n)
            (hunting_q && dn_valid) |-> dn_sop); // R9
    end else begin : g_plain
        AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
            !flush_req |-> (dn_valid == up_valid)); // R7
    end

endmodule

bind stream_flush_gate stream_flush_gate_checker #(
    .DATA_W     (DATA_W),
    .FRAMED_EXIT(FRAMED_EXIT)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush_req(flush_req),
    .up_data  (up_data),
    .up_valid (up_valid),
    .up_sop   (up_sop),
    .up_eop   (up_eop),
    .up_sync  (up_sync),
    .up_ready (up_ready),
    .dn_data  (dn_data),
    .dn_valid (dn_valid),
    .dn_sop   (dn_sop),
    .dn_eop   (dn_eop),
    .dn_sync  (dn_sync),
    .dn_ready (dn_ready)
);

// File: tb/stream_flush_gate_bench.sv
module stream_flush_gate_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int VW         = DW + 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_req = 1'b0;
    logic [DW-1:0] up_data = '0;
    logic up_valid = 1'b0, up_sop = 1'b0, up_eop = 1'b0, up_sync = 1'b0;
    logic dn_ready = 1'b0;

    logic up_ready_f, dn_valid_f, dn_sop_f, dn_eop_f, dn_sync_f;
    logic [DW-1:0] dn_data_f;
    logic up_ready_n, dn_valid_n, dn_sop_n, dn_eop_n, dn_sync_n;
    logic [DW-1:0] dn_data_n;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // FIFO model, entry layout {sync, eop, sop, data}
    logic [DW+2:0] fifo_q[$];
    bit hunt = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_flush_gate #(.DATA_W(DW), .FRAMED_EXIT(1'b1)) u_stream_flush_gate (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req),
        .up_data(up_data), .up_valid(up_valid), .up_sop(up_sop),
        .up_eop(up_eop), .up_sync(up_sync), .up_ready(up_ready_f),
        .dn_data(dn_data_f), .dn_valid(dn_valid_f), .dn_sop(dn_sop_f),
        .dn_eop(dn_eop_f), .dn_sync(dn_sync_f), .dn_ready(dn_ready)
    );

    stream_flush_gate #(.DATA_W(DW), .FRAMED_EXIT(1'b0)) u_stream_flush_gate_plain (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req),
        .up_data(up_data), .up_valid(up_valid), .up_sop(up_sop),
        .up_eop(up_eop), .up_sync(up_sync), .up_ready(up_ready_n),
        .dn_data(dn_data_n), .dn_valid(dn_valid_n), .dn_sop(dn_sop_n),
        .dn_eop(dn_eop_n), .dn_sync(dn_sync_n), .dn_ready(dn_ready)
    );

    task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] expect_vec(input bit disc, input bit rdy);
        logic v;
        v = up_valid && !disc;
        return {disc ? 1'b1 : rdy, v, up_sop && !disc, up_eop && !disc,
                up_sync && !disc, v ? up_data : {DW{1'b0}}};
    endfunction

    // one clock of stimulus, compare at the falling edge, model update after the rising edge
    task automatic step(input string tag, input bit fl, input bit rdy, input bit src);
        bit disc_f;
        bit disc_n;
        bit pop;
        flush_req = fl;
        dn_ready  = rdy;
        if (src && fifo_q.size() > 0) begin
            {up_sync, up_eop, up_sop, up_data} = fifo_q[0];
            up_valid = 1'b1;
        end else begin
            {up_sync, up_eop, up_sop, up_data} = '0;
            up_valid = 1'b0;
        end
        @(negedge clk);
        disc_f = fl || (hunt && !(up_valid && up_sop));
        disc_n = fl;
        check({tag, " framed"},
              {up_ready_f, dn_valid_f, dn_sop_f, dn_eop_f, dn_sync_f,
               dn_valid_f ? dn_data_f : {DW{1'b0}}},
              expect_vec(disc_f, rdy));
        check({tag, " plain"},
              {up_ready_n, dn_valid_n, dn_sop_n, dn_eop_n, dn_sync_n,
               dn_valid_n ? dn_data_n : {DW{1'b0}}},
              expect_vec(disc_n, rdy));
        pop = up_valid && (disc_f || rdy);
        @(posedge clk);
        #1;
        if (pop) fifo_q.delete(0);
        if (fl) hunt = 1'b1;
        else if (up_valid && up_sop) hunt = 1'b0;
    endtask

    task automatic push_pkt(input int len, input int base, input bit with_sync);
        for (int i = 0; i < len; i++) begin
            fifo_q.push_back({with_sync && i == 0, i == len - 1, i == 0, DW'(base + i)});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state passes a beat that lacks a start marker
        fifo_q.push_back({1'b0, 1'b0, 1'b0, DW'(16'h0A0A)});
        step("R1", 1'b0, 1'b1, 1'b1);
        check("R1 fifo", VW'(fifo_q.size()), VW'(0));

        // R2 R3: transparent passing with a stalling sink
        push_pkt(4, 16'h1000, 1'b1);
        push_pkt(3, 16'h2000, 1'b0);
        for (int i = 0; i < 12; i++) step("R2 R3", 1'b0, (i % 3) != 1, 1'b1);
        step("R2 idle", 1'b0, 1'b1, 1'b0);

        // R4 R5 R6: flush cuts a packet, sink stalled
        push_pkt(6, 16'h3000, 1'b0);
        step("R2", 1'b0, 1'b1, 1'b1);
        step("R2", 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) step("R4 R5 R6", 1'b1, 1'b0, 1'b1);

        // R7 R8: one tail beat remains; plain resumes, framed discards
        step("R7 R8", 1'b0, 1'b1, 1'b1);
        step("R8 idle", 1'b0, 1'b1, 1'b0);

        // R9: next start beat forwarded, including while sink stalls on it
        push_pkt(4, 16'h4000, 1'b1);
        step("R9 stall", 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) step("R9", 1'b0, 1'b1, 1'b1);

        // R10: start beat dropped under flush, hunt continues to next packet
        push_pkt(3, 16'h5000, 1'b0);
        push_pkt(2, 16'h6000, 1'b1);
        step("R10 flush sop", 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) step("R10", 1'b0, 1'b1, 1'b1);
        check("R10 fifo", VW'(fifo_q.size()), VW'(0));

        // R11: drain a full FIFO with the sink stalled
        push_pkt(5, 16'h7000, 1'b0);
        push_pkt(5, 16'h8000, 1'b1);
        for (int i = 0; i < 14; i++) step("R11 R4 R5", 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) step("R11 idle", 1'b0, 1'b0, 1'b1);
        check("R11 fifo empty", VW'(fifo_q.size()), VW'(0));

        // R8 R9 again: flush ends with non-start beats queued ahead of a packet
        fifo_q.push_back({1'b0, 1'b1, 1'b0, DW'(16'h9001)});
        push_pkt(2, 16'h9100, 1'b0);
        step("R8 R4", 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step("R8 R9", 1'b0, 1'b1, 1'b1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule